// File: doc/BRIEF.md
# CAN Controller Operating-Mode Sequencer

This block owns the operating mode of a CAN controller. Software writes a 16-bit control word that holds four things: a mode request, a sleep request, a bus-off recovery choice and a small set of configuration bits. The sequencer turns these requests into one effective mode: sleep, reset, halt or operation. It drives a one-hot set of mode enables to the protocol engine and shows the effective mode in a 16-bit status word, which software polls after it changes the mode.

Most moves out of operation wait until the protocol engine reports that the current bus transfer has ended. A forced reset does not wait. A sleep request overrides the mode field. When the node enters bus-off, the block can drop into halt on its own if the recovery field selects that. Configuration bits can only be changed while the controller is in reset.

Top module: `can_opmode_seq`

## Requirements
- R1: After reset the control word reads 0x0500 (sleep requested, mode field 01), the status word reads 0x0400, and the enable output is 4'b1000.
- R2: Control bits 9:8 choose the requested mode: 00 operation, 01 reset, 10 halt, 11 forced reset. The enables are one-hot in the order {sleep, halt, reset, operation}.
- R3: A request for reset, halt or sleep made while the effective mode is operation waits as long as bus_busy is high. It takes effect on the first edge at which bus_busy is low.
- R4: With sleep clear, mode field 11 moves the block to reset on the first clock edge after the control word holds it, even when bus_busy is high.
- R5: Control bit 10 set moves the block to sleep, with the same transfer wait as R3. While the bit stays set, the block remains in sleep whatever the mode field holds.
- R6: Leaving sleep takes a control write that clears bit 10. The mode field is then applied on the edge after that write.
- R7: If control bits 12:11 equal 01 and bus_off_evt is high while the block is in operation (mode field not 11, sleep clear), the block enters halt on that edge and control bits 9:8 become 10.
- R8: A bus_off_evt is ignored when bits 12:11 are not 01, or when the block is not in operation.
- R9: Status bit 8 is set only in reset, bit 9 only in halt and bit 10 only in sleep. All other status bits read 0. Status follows the effective mode, not a pending request.
- R10: Control bits 3:0 (bit 3 message-lost mode, bits 2:1 identifier format with bit 2 meaning mixed, bit 0 FIFO mailbox mode) take a write only when the effective mode is reset at the write edge. Otherwise they keep their value.
- R11: Control bits 15:13 and 7:4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word write data |
| bus_busy | input | 1 | Protocol engine has a transfer in progress |
| bus_off_evt | input | 1 | Single-cycle pulse on bus-off entry |
| ctrl_q | output | 16 | Control word readback |
| stat_q | output | 16 | Status word (mode indication) |
| eng_en | output | 4 | Mode enables {sleep, halt, reset, operation} |

## Verification
The assertions take it for granted that bus_off_evt is a pulse that the protocol engine raises only on entry to bus-off. They also assume that bus_busy comes from the same clock domain and changes only between edges. The stimulus drives every input on the falling edge and holds bus_busy steady for a whole test step. It raises bus_off_evt for exactly one cycle, and it reads results only after both the control register and the mode register have taken their edges.

// File: rtl/omc_pkg.sv
package omc_pkg;
  localparam int CTRL_W    = 16;
  localparam int CFG_W     = 4;
  localparam int MODE_LO   = 8;
  localparam int SLEEP_BIT = 10;
  localparam int BOM_LO    = 11;
  localparam int STAT_LO   = 8;
  localparam int N_MODES   = 4;
  localparam logic [1:0] BOM_AUTO_HALT = 2'b01;

  typedef enum logic [1:0] {
    REQ_RUN  = 2'b00,
    REQ_RST  = 2'b01,
    REQ_HALT = 2'b10,
    REQ_FRST = 2'b11
  } req_e;

  // effective mode; the encoding equals the enable bit index
  typedef enum logic [1:0] {
    EFF_RUN   = 2'd0,
    EFF_RESET = 2'd1,
    EFF_HALT  = 2'd2,
    EFF_SLEEP = 2'd3
  } eff_e;
endpackage

// File: rtl/omc_ctrl_reg.sv
module omc_ctrl_reg
  import omc_pkg::*;
#(
  parameter logic [CTRL_W-1:0] RST_VAL = 16'h0500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              cfg_open,
  input  logic              auto_halt,
  output logic [CTRL_W-1:0] ctrl_q
);
  localparam int MODE_HI = BOM_LO + 1;

  logic [CTRL_W-1:0] ctrl_d;
  logic              ctrl_en;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d[MODE_HI:MODE_LO] = wr_data[MODE_HI:MODE_LO];
      if (cfg_open) ctrl_d[CFG_W-1:0] = wr_data[CFG_W-1:0];
    end
    if (auto_halt) ctrl_d[MODE_LO+1:MODE_LO] = REQ_HALT;
    ctrl_d[CTRL_W-1:MODE_HI+1] = '0;
    ctrl_d[MODE_LO-1:CFG_W]    = '0;
  end

  assign ctrl_en = wr_en | auto_halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= RST_VAL;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/omc_mode_fsm.sv
module omc_mode_fsm
  import omc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic [1:0] mode_req,
  input  logic [1:0] bom_sel,
  input  logic       bus_busy,
  input  logic       bus_off_evt,
  output eff_e       state_q,
  output logic       auto_halt
);
  eff_e state_d;
  eff_e target;
  logic hold_xfer;

  always_comb begin
    unique case (req_e'(mode_req))
      REQ_RUN:  target = EFF_RUN;
      REQ_HALT: target = EFF_HALT;
      default:  target = EFF_RESET;
    endcase
  end

  assign hold_xfer = (state_q == EFF_RUN) & bus_busy;
  assign auto_halt = (state_q == EFF_RUN) & bus_off_evt & ~sleep_req &
                     (bom_sel == BOM_AUTO_HALT) & (req_e'(mode_req) != REQ_FRST);

  always_comb begin
    state_d = state_q;
    if (auto_halt) begin
      state_d = EFF_HALT;
    end else if (sleep_req) begin
      if (!hold_xfer) state_d = EFF_SLEEP;
    end else if (req_e'(mode_req) == REQ_FRST) begin
      state_d = EFF_RESET;
    end else if (!(hold_xfer && target != EFF_RUN)) begin
      state_d = target;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= EFF_SLEEP;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/omc_status_dec.sv
module omc_status_dec
  import omc_pkg::*;
(
  input  eff_e              state_q,
  output logic [N_MODES-1:0] eng_en,
  output logic [CTRL_W-1:0]  stat_q
);
  for (genvar i = 0; i < N_MODES; i++) begin : g_en
    assign eng_en[i] = (state_q == eff_e'(i));
  end

  always_comb begin
    stat_q = '0;
    stat_q[STAT_LO +: N_MODES-1] = eng_en[N_MODES-1:1];
  end
endmodule

// File: rtl/can_opmode_seq.sv
module can_opmode_seq
  import omc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        bus_busy,
  input  logic        bus_off_evt,
  output logic [15:0] ctrl_q,
  output logic [15:0] stat_q,
  output logic [3:0]  eng_en
);
  eff_e state_q;
  logic auto_halt;

  omc_ctrl_reg #(.RST_VAL(16'h0500)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_open(state_q == EFF_RESET), .auto_halt(auto_halt), .ctrl_q(ctrl_q)
  );

  omc_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .sleep_req(ctrl_q[SLEEP_BIT]),
    .mode_req(ctrl_q[MODE_LO+1:MODE_LO]),
    .bom_sel(ctrl_q[BOM_LO+1:BOM_LO]),
    .bus_busy(bus_busy), .bus_off_evt(bus_off_evt),
    .state_q(state_q), .auto_halt(auto_halt)
  );

  omc_status_dec u_stat (
    .state_q(state_q), .eng_en(eng_en), .stat_q(stat_q)
  );
endmodule

// File: rtl/omc_checker.sv
module omc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] ctrl_q,
  input logic [15:0] stat_q,
  input logic        bus_busy,
  input logic        bus_off_evt,
  input logic [3:0]  eng_en
);
  // R2: exactly one effective mode
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(eng_en) == 1);

  // R3: reset/halt request held off by an active transfer
  p_wait_xfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_en[0] && bus_busy && !bus_off_evt && !ctrl_q[10] &&
     (ctrl_q[9:8] == 2'b01 || ctrl_q[9:8] == 2'b10)) |=> eng_en[0]);

  // R4: forced reset needs no idle bus
  p_force_rst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[10] && ctrl_q[9:8] == 2'b11) |=> eng_en[1]);

  // R5: sleep persists while requested
  p_sleep_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_en[3] && ctrl_q[10]) |=> eng_en[3]);

  // R7: automatic halt on bus-off
  p_busoff_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_en[0] && bus_off_evt && ctrl_q[12:11] == 2'b01 &&
     !ctrl_q[10] && ctrl_q[9:8] != 2'b11) |=> (eng_en[2] && ctrl_q[9:8] == 2'b10));

  // R9: reset status appears only after a reset-type request
  p_rst_stat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[8]) |-> $past(ctrl_q[8]));

  // R10: configuration bits frozen outside reset
  p_cfg_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_en[1] |=> $stable(ctrl_q[3:0]));

  // R11: reserved control bits stay zero
  p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[15:13] == 3'b000 && ctrl_q[7:4] == 4'b0000));
endmodule

bind can_opmode_seq omc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .stat_q(stat_q),
  .bus_busy(bus_busy), .bus_off_evt(bus_off_evt), .eng_en(eng_en)
);

// File: tb/sim_can_opmode_seq.sv
`timescale 1ns/1ps
module sim_can_opmode_seq;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_data;
  logic        bus_busy;
  logic        bus_off_evt;
  logic [15:0] ctrl_q;
  logic [15:0] stat_q;
  logic [3:0]  eng_en;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  can_opmode_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .bus_busy(bus_busy), .bus_off_evt(bus_off_evt),
    .ctrl_q(ctrl_q), .stat_q(stat_q), .eng_en(eng_en)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {write data, bus_busy, status[10:8], enables {sleep,halt,reset,run}}
  localparam int NV = 13;
  localparam logic [23:0] VEC [NV] = '{
    {16'h0100, 1'b0, 3'b001, 4'b0010},  // R6 wake into reset
    {16'h0000, 1'b0, 3'b000, 4'b0001},  // R2 operation
    {16'h0200, 1'b0, 3'b010, 4'b0100},  // R2 halt
    {16'h0000, 1'b0, 3'b000, 4'b0001},
    {16'h0100, 1'b1, 3'b000, 4'b0001},  // R3 reset waits, R9 status unchanged
    {16'h0100, 1'b0, 3'b001, 4'b0010},  // R3 applied after idle
    {16'h0000, 1'b0, 3'b000, 4'b0001},
    {16'h0300, 1'b1, 3'b001, 4'b0010},  // R4 forced reset while busy
    {16'h0000, 1'b0, 3'b000, 4'b0001},
    {16'h0200, 1'b1, 3'b000, 4'b0001},  // R3 halt waits
    {16'h0700, 1'b0, 3'b100, 4'b1000},  // R5 sleep entry
    {16'h0400, 1'b0, 3'b100, 4'b1000},  // R5 mode ignored in sleep
    {16'h0200, 1'b0, 3'b010, 4'b0100}   // R6 leave sleep into halt
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d, input logic b);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; bus_busy = b;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_busoff();
    @(negedge clk);
    bus_off_evt = 1'b1;
    @(negedge clk);
    bus_off_evt = 1'b0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; bus_busy = 1'b0; bus_off_evt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctrl", ctrl_q, 16'h0500);
    chk("R1 stat", stat_q, 16'h0400);
    chk("R1 eng",  {12'h0, eng_en}, 16'h0008);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][23:8], VEC[i][7]);
      chk($sformatf("R2/R9 stat row%0d", i), stat_q, {5'b0, VEC[i][6:4], 8'h00});
      chk($sformatf("R2 eng row%0d", i), {12'h0, eng_en}, {12'h0, VEC[i][3:0]});
    end

    // now in halt; configuration write ignored outside reset
    wr(16'h010D, 1'b0);
    chk("R10 cfg ignored in halt", ctrl_q, 16'h0100);
    wr(16'h010D, 1'b0);
    chk("R10 cfg taken in reset", ctrl_q, 16'h010D);
    wr(16'h000D, 1'b0);
    chk("R10 run", {12'h0, eng_en}, 16'h0001);
    wr(16'hE0F2, 1'b0);
    chk("R10 R11 ctrl", ctrl_q, 16'h000D);

    // bus-off auto halt
    wr(16'h0800, 1'b0);
    chk("R7 ctrl before", ctrl_q, 16'h080D);
    pulse_busoff();
    chk("R7 eng", {12'h0, eng_en}, 16'h0004);
    chk("R7 ctrl mode", ctrl_q, 16'h0A0D);
    chk("R9 halt stat", stat_q, 16'h0200);
    pulse_busoff();
    chk("R8 not in run", {12'h0, eng_en}, 16'h0004);

    // bus-off with recovery field 00 and 10
    wr(16'h0000, 1'b0);
    chk("R8 run", {12'h0, eng_en}, 16'h0001);
    pulse_busoff();
    chk("R8 bom00", {12'h0, eng_en}, 16'h0001);
    wr(16'h1000, 1'b0);
    pulse_busoff();
    chk("R8 bom10", {12'h0, eng_en}, 16'h0001);
    chk("R8 ctrl", ctrl_q, 16'h100D);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule